// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a short burst on a synchronous memory port. A single starting address is loaded together with the access type (read or write) and the chip-select state. After that, each advance cycle moves on to the next address of the burst, and no new address needs to be presented. Only the two least significant address bits step. The upper bits stay at the loaded value, so the sequence wraps inside an aligned group of four addresses.

Two orders are supported, and the order is picked by the `interleave` pin when the burst is loaded. The linear order adds the beat number to the starting low bits, modulo four. The interleaved order XORs the beat number into the starting low bits. The access type and the select state are captured when the burst is loaded and are held for every beat. A `freeze` input stops the whole block for a cycle, in the same way a deasserted clock enable would.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, `beat_addr` is 0, `beat_wr` is 0 and `active` is 0.
- R2: A rising edge with `freeze`=0 and `advance`=0 loads a burst. From the next sample onward, `beat_addr` equals `start_addr`, `beat_wr` equals `start_wr`, and `active` equals `chip_sel`.
- R3: When `interleave` is 0 at load, the n-th advance after the load gives `beat_addr[1:0]` = (start low bits + n) mod 4.
- R4: When `interleave` is 1 at load, the n-th advance after the load gives `beat_addr[1:0]` = start low bits XOR (n mod 4).
- R5: Advances never change `beat_addr[AW-1:2]`. Advancing past the fourth beat keeps wrapping, so the fifth beat again shows the starting address.
- R6: A rising edge with `freeze`=0 and `advance`=1 leaves `beat_wr` and `active` unchanged, whatever the levels on `start_wr`, `chip_sel` and `start_addr`.
- R7: A rising edge with `freeze`=1 leaves `beat_addr`, `beat_wr` and `active` unchanged, whether `advance` is 0 or 1.
- R8: The order is taken from `interleave` only at load. Changing `interleave` during a burst does not alter the sequence of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| freeze | input | 1 | 1 = hold all state this cycle |
| advance | input | 1 | 1 = step to the next beat, 0 = load a new burst |
| chip_sel | input | 1 | Select state, captured at load |
| start_addr | input | AW | Starting address of a burst |
| start_wr | input | 1 | Access type at load: 1 = write, 0 = read |
| interleave | input | 1 | Order at load: 0 = linear, 1 = interleaved |
| beat_addr | output | AW | Address of the current beat |
| beat_wr | output | 1 | Access type of the current burst |
| active | output | 1 | Select state of the current burst |

## Verification
A hold request and a load or advance can arrive in the same cycle, and the hold must win. The bench provokes this by raising `freeze` while `advance` is 0 and a different address, type, select and order sit on the inputs. It does the same again with `advance` at 1. After each such edge it checks that all three outputs still show the earlier burst state. It then releases `freeze` and confirms that the pending load takes effect only on that edge.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int unsigned LOW_W = 2;

  typedef enum logic {
    SEQ_LINEAR = 1'b0,
    SEQ_XOR    = 1'b1
  } seq_mode_e;

  // Low address bits for beat number n of a burst that started at base.
  function automatic logic [LOW_W-1:0] beat_low(
    input logic [LOW_W-1:0] base,
    input logic [LOW_W-1:0] n,
    input seq_mode_e        mode
  );
    logic [LOW_W-1:0] r;
    if (mode == SEQ_XOR) r = base ^ n;
    else                 r = base + n;  // wraps modulo 2**LOW_W
    return r;
  endfunction
endpackage

// File: rtl/bseq_capture.sv
module bseq_capture
  import bseq_pkg::*;
#(
  parameter int unsigned AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_evt,
  input  logic [AW-1:0] start_addr,
  input  logic          start_wr,
  input  logic          chip_sel,
  input  logic          interleave,
  output logic [AW-1:0] base_q,
  output logic          wr_q,
  output logic          act_q,
  output seq_mode_e     mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      wr_q   <= 1'b0;
      act_q  <= 1'b0;
      mode_q <= SEQ_LINEAR;
    end else if (load_evt) begin
      base_q <= start_addr;
      wr_q   <= start_wr;
      act_q  <= chip_sel;
      mode_q <= seq_mode_e'(interleave);
    end
  end
endmodule

// File: rtl/bseq_counter.sv
module bseq_counter
  import bseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_evt,
  input  logic             adv_evt,
  output logic [LOW_W-1:0] cnt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (load_evt) cnt_q <= '0;
    else if (adv_evt)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bseq_addr_mix.sv
module bseq_addr_mix
  import bseq_pkg::*;
#(
  parameter int unsigned AW = 20
) (
  input  logic [AW-1:0]    base_q,
  input  logic [LOW_W-1:0] cnt_q,
  input  seq_mode_e        mode_q,
  output logic [AW-1:0]    addr
);
  localparam int unsigned HI_W = AW - LOW_W;

  generate
    if (HI_W > 0) begin : g_hi
      assign addr[AW-1:LOW_W] = base_q[AW-1:LOW_W];
    end
  endgenerate

  assign addr[LOW_W-1:0] = beat_low(base_q[LOW_W-1:0], cnt_q, mode_q);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int unsigned AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          freeze,
  input  logic          advance,
  input  logic          chip_sel,
  input  logic [AW-1:0] start_addr,
  input  logic          start_wr,
  input  logic          interleave,
  output logic [AW-1:0] beat_addr,
  output logic          beat_wr,
  output logic          active
);
  // Named events, visible to the checker.
  logic load_evt;
  logic adv_evt;
  assign load_evt = !freeze && !advance;
  assign adv_evt  = !freeze &&  advance;

  logic [AW-1:0]    base_q;
  logic [LOW_W-1:0] cnt_q;
  seq_mode_e        mode_q;

  bseq_capture #(.AW(AW)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_evt   (load_evt),
    .start_addr (start_addr),
    .start_wr   (start_wr),
    .chip_sel   (chip_sel),
    .interleave (interleave),
    .base_q     (base_q),
    .wr_q       (beat_wr),
    .act_q      (active),
    .mode_q     (mode_q)
  );

  bseq_counter u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .adv_evt  (adv_evt),
    .cnt_q    (cnt_q)
  );

  bseq_addr_mix #(.AW(AW)) u_mix (
    .base_q (base_q),
    .cnt_q  (cnt_q),
    .mode_q (mode_q),
    .addr   (beat_addr)
  );
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
  import bseq_pkg::*;
#(
  parameter int unsigned AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          freeze,
  input logic [AW-1:0] start_addr,
  input logic          start_wr,
  input logic          chip_sel,
  input logic          load_evt,
  input logic          adv_evt,
  input seq_mode_e     mode_q,
  input logic [AW-1:0] beat_addr,
  input logic          beat_wr,
  input logic          active
);
  always_comb begin
    if (!rst_n) a_r1_reset_clear: assert (beat_addr == '0 && !beat_wr && !active);
  end

  a_r2_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (beat_addr == $past(start_addr) && beat_wr == $past(start_wr)
                  && active == $past(chip_sel)));

  a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && mode_q == SEQ_LINEAR) |=>
      beat_addr[1:0] == $past(beat_addr[1:0]) + 2'd1);

  a_r4_xor_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && mode_q == SEQ_XOR) |=>
      $countones(beat_addr[1:0] ^ $past(beat_addr[1:0])) >= 1);

  a_r5_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> beat_addr[AW-1:2] == $past(beat_addr[AW-1:2]));

  a_r6_type_kept: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> ($stable(beat_wr) && $stable(active)));

  a_r7_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(beat_addr) && $stable(beat_wr) && $stable(active)));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .freeze     (freeze),
  .start_addr (start_addr),
  .start_wr   (start_wr),
  .chip_sel   (chip_sel),
  .load_evt   (load_evt),
  .adv_evt    (adv_evt),
  .mode_q     (mode_q),
  .beat_addr  (beat_addr),
  .beat_wr    (beat_wr),
  .active     (active)
);

// File: tb/burst_addr_seq_tb_top.sv
`timescale 1ns/1ps
module burst_addr_seq_tb_top;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          freeze = 1'b0;
  logic          advance = 1'b1;
  logic          chip_sel = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          start_wr = 1'b0;
  logic          interleave = 1'b0;
  logic [AW-1:0] beat_addr;
  logic          beat_wr;
  logic          active;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;  // 250 MHz

  burst_addr_seq #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .advance(advance),
    .chip_sel(chip_sel), .start_addr(start_addr), .start_wr(start_wr),
    .interleave(interleave), .beat_addr(beat_addr), .beat_wr(beat_wr),
    .active(active)
  );

  task automatic chk(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Low bits expected on beat n, written independently of the design.
  function automatic logic [1:0] exp_low(input logic [1:0] s, input int n, input bit xr);
    int k;
    k = n % 4;
    if (xr) return {s[1] ^ k[1], s[0] ^ k[0]};
    return 2'((int'(s) + k) % 4);
  endfunction

  task automatic do_load(input logic [AW-1:0] a, input bit wr, input bit cs, input bit xr);
    freeze = 0; advance = 0; start_addr = a; start_wr = wr; chip_sel = cs; interleave = xr;
    step();
    advance = 1;
  endtask

  task automatic t_reset();
    chk("R1 addr", beat_addr, '0);
    chk("R1 wr", AW'(beat_wr), '0);
    chk("R1 active", AW'(active), '0);
  endtask

  task automatic t_load();
    do_load(20'hABCD6, 1'b1, 1'b1, 1'b0);
    chk("R2 addr", beat_addr, 20'hABCD6);
    chk("R2 wr", AW'(beat_wr), 1);
    chk("R2 active", AW'(active), 1);
    do_load(20'h12345, 1'b0, 1'b0, 1'b0);
    chk("R2 addr2", beat_addr, 20'h12345);
    chk("R2 wr2", AW'(beat_wr), 0);
    chk("R2 deselect", AW'(active), 0);
  endtask

  task automatic t_linear();
    do_load(20'h5A5A6, 1'b0, 1'b1, 1'b0);
    for (int n = 1; n <= 3; n++) begin
      step();
      chk("R3 linear low", AW'(beat_addr[1:0]), AW'(exp_low(2'd2, n, 1'b0)));
      chk("R5 upper", AW'(beat_addr[AW-1:2]), AW'(20'h5A5A6 >> 2));
    end
  endtask

  task automatic t_xor_wrap();
    do_load(20'hF00F3, 1'b1, 1'b1, 1'b1);
    for (int n = 1; n <= 6; n++) begin
      step();
      chk("R4 xor low", AW'(beat_addr[1:0]), AW'(exp_low(2'd3, n, 1'b1)));
      chk("R5 upper", AW'(beat_addr[AW-1:2]), AW'(20'hF00F3 >> 2));
    end
    do_load(20'h00401, 1'b0, 1'b1, 1'b0);
    for (int n = 1; n <= 4; n++) step();
    chk("R5 fifth beat wraps to start", beat_addr, 20'h00401);
  endtask

  task automatic t_adv_ignore();
    do_load(20'h33330, 1'b1, 1'b1, 1'b0);
    start_wr = 0; chip_sel = 0; start_addr = 20'hFFFFF;
    step();
    chk("R6 wr kept", AW'(beat_wr), 1);
    chk("R6 active kept", AW'(active), 1);
    chk("R6 addr steps", beat_addr, 20'h33331);
  endtask

  task automatic t_mode_latched();
    do_load(20'h00012, 1'b0, 1'b1, 1'b0);
    interleave = 1;
    step(); step();
    chk("R8 linear kept", AW'(beat_addr[1:0]), AW'(exp_low(2'd2, 2, 1'b0)));
    do_load(20'h00011, 1'b0, 1'b1, 1'b1);
    interleave = 0;
    step(); step(); step();
    chk("R8 xor kept", AW'(beat_addr[1:0]), AW'(exp_low(2'd1, 3, 1'b1)));
  endtask

  task automatic t_freeze_collide();
    do_load(20'h44444, 1'b1, 1'b1, 1'b0);
    step();
    freeze = 1; advance = 0; start_addr = 20'h77777; start_wr = 0; chip_sel = 0; interleave = 1;
    step();
    chk("R7 load blocked addr", beat_addr, 20'h44445);
    chk("R7 load blocked wr", AW'(beat_wr), 1);
    chk("R7 load blocked active", AW'(active), 1);
    advance = 1;
    step();
    chk("R7 advance blocked", beat_addr, 20'h44445);
    freeze = 0; advance = 0;
    step();
    advance = 1;
    chk("R7 release loads", beat_addr, 20'h77777);
    chk("R7 release wr", AW'(beat_wr), 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_load();
    t_linear();
    t_xor_wrap();
    t_adv_ignore();
    t_mode_latched();
    t_freeze_collide();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule